// File: doc/BRIEF.md
# Single-Cycle Subset Processor Datapath

This block is the 32-bit datapath of a processor that completes one instruction per clock. On every cycle it fetches the word that the program counter addresses, reads two registers, and forms an ALU result. When the instruction asks for it, the block also touches data memory. It then writes a result back and moves the program counter on. It implements a small instruction subset: register-register add, sub, and, or and set-less-than, word load, word store, and branch-if-equal.

The instruction decoder is outside the block. The datapath exports the fetched instruction word on `instr_o` and takes back the seven one-bit steering controls and a 4-bit ALU operation code. Instruction and data memories are small behavioural word arrays inside the block. A load port fills them while reset is held. The write-back, store and program-counter activity appears on outputs, so an environment can follow the architectural state cycle by cycle.

The block has no sequencer, so it has no states or transitions. The program counter is its only control register: it is cleared by reset and then advances or branches once per clock.

Top module: `sc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and all registers read 0 afterwards.
- R2: When a branch is not taken, the next program counter is the current one plus 4.
- R3: When `branch` is high and the ALU zero flag is high, the next program counter is (current + 4) plus the sign-extended instruction bits [15:0] shifted left by 2. This applies to both positive and negative offsets.
- R4: A branch instruction whose operands differ (zero flag low) falls through to current + 4.
- R5: The write destination is instruction bits [20:16] when `reg_dst` is 0 and bits [15:11] when it is 1. The read ports take rs from bits [25:21] and rt from bits [20:16]. The opcode is in bits [31:26] and funct is in bits [5:0].
- R6: The second ALU operand is register read data 2 when `alu_src` is 0 and the sign-extended bits [15:0] when it is 1.
- R7: The write-back value is the data-memory read word when `mem_to_reg` is 1 and the ALU result when it is 0.
- R8: With `mem_write` high, register read data 2 is stored at the word the ALU result addresses (byte address bits [7:2] for 64 words). A later load of that word returns the stored value.
- R9: `alu_ctl` codes: 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 signed set-less-than (result 1 or 0). The zero flag is high when the result is 0.
- R10: Register 0 always reads 0, and writes to it are discarded.
- R11: `dm_rdata_o` is 0 whenever `mem_read` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset |
| ld_en | input | 1 | Memory preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | 6 | Preload word index |
| ld_data | input | 32 | Preload word |
| instr_o | output | 32 | Fetched instruction, to the external decoder |
| reg_dst | input | 1 | Destination select (R5) |
| reg_write | input | 1 | Register write enable |
| alu_src | input | 1 | Second operand select (R6) |
| mem_read | input | 1 | Data-memory read enable |
| mem_write | input | 1 | Data-memory write enable |
| mem_to_reg | input | 1 | Write-back select (R7) |
| branch | input | 1 | Branch instruction flag |
| alu_ctl | input | 4 | ALU operation code (R9) |
| pc_o | output | 32 | Current program counter |
| zero_o | output | 1 | ALU zero flag |
| rf_we_o | output | 1 | Register write enable this cycle |
| rf_waddr_o | output | 5 | Register written this cycle |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-memory write this cycle |
| dm_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-memory store value |
| dm_rdata_o | output | 32 | Data-memory read value |

## Verification
The hardest case to reach is a taken branch. It needs two things in the same cycle: the decoder's branch flag, and a zero ALU result computed from registers that earlier loads and arithmetic have filled. The program therefore loads values, subtracts a register from itself, and branches forward over two instructions that must never write. It ends on a branch with offset -1 that jumps to itself. A behavioural model in the bench runs the same program and compares the program counter, write-back and store ports on every clock. The bench then checks the final register values seen at the write-back port against hand-computed constants.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_op_e;

    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
endpackage

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic [XLEN-1:0] imm_ext,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] pc_d;

    always_comb begin
        seq_pc = pc_q + XLEN'(4);
        pc_d   = take ? (seq_pc + (imm_ext << 2)) : seq_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;

    p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc_q == '0);
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        !take |=> pc_q == $past(pc_q) + XLEN'(4));
    p_branch_target_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_ext) << 2));
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NREGS)-1:0] ra1,
    input  logic [$clog2(NREGS)-1:0] ra2,
    output logic [XLEN-1:0]          rd1,
    output logic [XLEN-1:0]          rd2,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [XLEN-1:0]          wd
);
    localparam int AW = $clog2(NREGS);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    always_comb begin
        rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
        rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];
    end

    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));
    p_zero_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (we && wa == '0) |=> regs[0] == '0);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [3:0]      op,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        case (alu_op_e'(op))
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int XLEN  = 32,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] widx,
    input  logic [XLEN-1:0]          wdata,
    input  logic                     re,
    input  logic [$clog2(WORDS)-1:0] ridx,
    output logic [XLEN-1:0]          rdata
);
    logic [XLEN-1:0] arr [WORDS];

    always_ff @(posedge clk) begin
        if (we) arr[widx] <= wdata;
    end

    assign rdata = re ? arr[ridx] : '0;

    p_store_lands_r8: assert property (@(posedge clk)
        we |=> arr[$past(widx)] == $past(wdata));
    p_read_gate_r11: assert property (@(posedge clk)
        !re |-> rdata == '0);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
    import sc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREGS      = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IM_AW     = $clog2(IMEM_WORDS),
    localparam int DM_AW     = $clog2(DMEM_WORDS),
    localparam int LD_AW     = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_dmem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]  ld_data,
    output logic [31:0]      instr_o,
    input  logic             reg_dst,
    input  logic             reg_write,
    input  logic             alu_src,
    input  logic             mem_read,
    input  logic             mem_write,
    input  logic             mem_to_reg,
    input  logic             branch,
    input  logic [3:0]       alu_ctl,
    output logic [XLEN-1:0]  pc_o,
    output logic             zero_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             dm_we_o,
    output logic [XLEN-1:0]  dm_addr_o,
    output logic [XLEN-1:0]  dm_wdata_o,
    output logic [XLEN-1:0]  dm_rdata_o
);
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr_w;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rd1, rd2, op_b, alu_y, mem_q, wb_val;
    logic            zero, take;
    logic [REG_W-1:0] rs, rt, rd, dst;
    logic            im_we, dm_we;
    logic [DM_AW-1:0] dm_idx;
    logic [XLEN-1:0] dm_wd;

    // fetch
    assign im_we = ld_en && !ld_dmem;

    sc_mem #(.XLEN(XLEN), .WORDS(IMEM_WORDS)) u_imem (
        .clk(clk), .we(im_we), .widx(ld_addr[IM_AW-1:0]), .wdata(ld_data),
        .re(1'b1), .ridx(pc[IM_AW+1:2]), .rdata(instr_w)
    );

    assign instr_o = instr_w[31:0];

    // operand fields and steering
    always_comb begin
        rs      = instr_w[RS_LSB +: REG_W];
        rt      = instr_w[RT_LSB +: REG_W];
        rd      = instr_w[RD_LSB +: REG_W];
        dst     = reg_dst ? rd : rt;
        imm_ext = {{(XLEN-IMM_W){instr_w[IMM_W-1]}}, instr_w[IMM_W-1:0]};
        op_b    = alu_src ? imm_ext : rd2;
        wb_val  = mem_to_reg ? mem_q : alu_y;
        take    = branch && zero;
    end

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst(rst), .ra1(rs), .ra2(rt), .rd1(rd1), .rd2(rd2),
        .we(reg_write), .wa(dst), .wd(wb_val)
    );

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a(rd1), .b(op_b), .op(alu_ctl), .y(alu_y), .zero(zero)
    );

    // data memory: preload port wins over datapath stores
    always_comb begin
        dm_we  = (ld_en && ld_dmem) || mem_write;
        dm_idx = (ld_en && ld_dmem) ? ld_addr[DM_AW-1:0] : alu_y[DM_AW+1:2];
        dm_wd  = (ld_en && ld_dmem) ? ld_data : rd2;
    end

    sc_mem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
        .clk(clk), .we(dm_we), .widx(dm_idx), .wdata(dm_wd),
        .re(mem_read), .ridx(alu_y[DM_AW+1:2]), .rdata(mem_q)
    );

    sc_pc_unit #(.XLEN(XLEN)) u_pc (
        .clk(clk), .rst(rst), .take(take), .imm_ext(imm_ext), .pc(pc)
    );

    assign pc_o       = pc;
    assign zero_o     = zero;
    assign rf_we_o    = reg_write;
    assign rf_waddr_o = dst;
    assign rf_wdata_o = wb_val;
    assign dm_we_o    = mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;
    assign dm_rdata_o = mem_q;

    p_r0_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_write && rt == '0) |-> dm_wdata_o == '0);
endmodule

// File: tb/sim_sc_datapath.sv
module sim_sc_datapath;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 1'b0, ld_dmem = 1'b0;
    logic [5:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] instr_o;
    logic reg_dst, reg_write, alu_src, mem_read, mem_write, mem_to_reg, branch;
    logic [3:0] alu_ctl;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o, dm_rdata_o;
    logic zero_o, rf_we_o, dm_we_o;
    logic [4:0] rf_waddr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] prog [64];
    logic [31:0] mimem [64];
    logic [31:0] mdmem [64];
    logic [31:0] mregs [32];
    logic [31:0] mpc;
    logic [31:0] obs_reg [32];
    logic [31:0] obs_word5;
    string pc_tag;

    always #5 clk = ~clk;

    sc_datapath u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
        .ld_data(ld_data), .instr_o(instr_o), .reg_dst(reg_dst), .reg_write(reg_write),
        .alu_src(alu_src), .mem_read(mem_read), .mem_write(mem_write),
        .mem_to_reg(mem_to_reg), .branch(branch), .alu_ctl(alu_ctl), .pc_o(pc_o),
        .zero_o(zero_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
        .dm_wdata_o(dm_wdata_o), .dm_rdata_o(dm_rdata_o)
    );

    // external decoder stand-in
    always_comb begin
        {reg_dst, reg_write, alu_src, mem_read, mem_write, mem_to_reg, branch} = '0;
        alu_ctl = 4'b0010;
        case (instr_o[31:26])
            6'h00: begin
                reg_dst = 1; reg_write = 1;
                case (instr_o[5:0])
                    6'h20: alu_ctl = 4'b0010;
                    6'h22: alu_ctl = 4'b0110;
                    6'h24: alu_ctl = 4'b0000;
                    6'h25: alu_ctl = 4'b0001;
                    6'h2A: alu_ctl = 4'b0111;
                    default: alu_ctl = 4'b0000;
                endcase
            end
            6'h23: begin alu_src = 1; mem_read = 1; mem_to_reg = 1; reg_write = 1; end
            6'h2B: begin alu_src = 1; mem_write = 1; end
            6'h04: begin branch = 1; alu_ctl = 4'b0110; end
            default: ;
        endcase
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one behavioural step of the reference, compared to the ports
    task automatic step();
        logic [31:0] ins, a, b, imm, opb, res, wd, nxt;
        int op, fn, rs, rt, rd, wa;
        bit we, mw, lw, br, rtype;
        ins = mimem[mpc[7:2]];
        op = int'(ins[31:26]); fn = int'(ins[5:0]);
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = mregs[rs]; b = mregs[rt];
        imm = {{16{ins[15]}}, ins[15:0]};
        rtype = (op == 0); lw = (op == 'h23); mw = (op == 'h2B); br = (op == 4);
        we = rtype || lw;
        opb = (lw || mw) ? imm : b;
        if (rtype) begin
            case (fn)
                'h20: res = a + opb;
                'h22: res = a - opb;
                'h24: res = a & opb;
                'h25: res = a | opb;
                'h2A: res = ($signed(a) < $signed(opb)) ? 32'd1 : 32'd0;
                default: res = a & opb;
            endcase
        end else if (br) res = a - b;
        else res = a + opb;
        wa = rtype ? rd : rt;
        wd = lw ? mdmem[res[7:2]] : res;

        check(pc_tag, pc_o, mpc);
        check("R5 write enable", {31'd0, rf_we_o}, {31'd0, we});
        if (we) begin
            check("R5 destination", {27'd0, rf_waddr_o}, 32'(wa));
            check(lw ? "R7 load write-back" : "R9 ALU write-back", rf_wdata_o, wd);
        end
        check("R8 store enable", {31'd0, dm_we_o}, {31'd0, mw});
        if (mw) begin
            check("R6 store address", dm_addr_o, res);
            check("R8 store data", dm_wdata_o, b);
            if (res[7:2] == 6'd5) obs_word5 = dm_wdata_o;
        end
        if (!lw) check("R11 read gate", dm_rdata_o, 32'd0);
        if (br) check("R9 zero flag", {31'd0, zero_o}, {31'd0, (res == 0)});

        if (rf_we_o && rf_waddr_o != 0) obs_reg[rf_waddr_o] = rf_wdata_o;

        if (we && wa != 0) mregs[wa] = wd;
        if (mw) mdmem[res[7:2]] = b;
        nxt = mpc + 4;
        if (br && res == 0) begin
            nxt = nxt + (imm << 2);
            pc_tag = "R3 taken branch";
        end else if (br) pc_tag = "R4 untaken branch";
        else pc_tag = "R2 sequential";
        mpc = nxt;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin prog[i] = 32'd0; mdmem[i] = 32'd0; end
        for (int i = 0; i < 32; i++) begin mregs[i] = 32'd0; obs_reg[i] = 32'hDEAD_BEEF; end
        obs_word5 = 32'hDEAD_BEEF;
        mdmem[0] = 32'd5; mdmem[1] = 32'd3; mdmem[2] = 32'hFFFF_FFF9; mdmem[3] = 32'h0000_0F0F;
        prog[0]  = enc_i('h23, 0, 1, 0);
        prog[1]  = enc_i('h23, 0, 2, 4);
        prog[2]  = enc_i('h23, 0, 3, 8);
        prog[3]  = enc_r(1, 2, 4, 'h20);
        prog[4]  = enc_r(1, 2, 5, 'h22);
        prog[5]  = enc_r(1, 2, 6, 'h24);
        prog[6]  = enc_r(1, 2, 7, 'h25);
        prog[7]  = enc_r(3, 1, 8, 'h2A);
        prog[8]  = enc_r(1, 3, 9, 'h2A);
        prog[9]  = enc_i('h2B, 0, 4, 16);
        prog[10] = enc_r(1, 2, 0, 'h20);
        prog[11] = enc_i('h2B, 0, 0, 20);
        prog[12] = enc_i('h04, 1, 2, 5);
        prog[13] = enc_i('h04, 5, 5, 2);
        prog[14] = enc_r(1, 1, 10, 'h20);
        prog[15] = enc_r(2, 2, 10, 'h20);
        prog[16] = enc_i('h23, 0, 11, 16);
        prog[17] = enc_i('h2B, 4, 3, -4);
        prog[18] = enc_i('h23, 0, 12, 4);
        prog[19] = enc_i('h04, 0, 0, -1);
        for (int i = 0; i < 64; i++) mimem[i] = prog[i];

        repeat (2) @(posedge clk);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ld_en = 1; ld_dmem = 0; ld_addr = 6'(i); ld_data = prog[i];
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ld_en = 1; ld_dmem = 1; ld_addr = 6'(i); ld_data = mdmem[i];
        end
        @(negedge clk);
        ld_en = 0;
        check("R1 reset pc", pc_o, 32'd0);
        rst = 0;
        mpc = 32'd0;
        pc_tag = "R1 first fetch after reset";
        #1;
        step();
        for (int c = 0; c < 29; c++) begin
            @(negedge clk);
            step();
        end

        check("R9 add", obs_reg[4], 32'd8);
        check("R9 sub", obs_reg[5], 32'd2);
        check("R9 and", obs_reg[6], 32'd1);
        check("R9 or", obs_reg[7], 32'd7);
        check("R9 slt true", obs_reg[8], 32'd1);
        check("R9 slt false", obs_reg[9], 32'd0);
        check("R3 skipped writes", obs_reg[10], 32'hDEAD_BEEF);
        check("R7 load of stored word", obs_reg[11], 32'd8);
        check("R8 negative-offset store", obs_reg[12], 32'hFFFF_FFF9);
        check("R10 r0 stored as zero", obs_word5, 32'd0);
        check("R3 self branch holds pc", pc_o, 32'd76);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule